// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is a small register slave on a three-wire serial bus whose single data line carries traffic in both directions. The master opens a frame by pulling chip select low. For the frame's first clocks it sends a 6-bit register address, most significant bit first, and then a direction flag. A write frame adds one pad clock and then eight data bits from the master. A read frame adds one turnaround clock, during which nobody drives the line, and then eight data bits that the slave drives.

The register file has four registers:

- a scratch register, used by the master to test the link;
- a read-only identity register, with the chip code in the upper nibble and the revision in the lower nibble;
- a resolution register holding a 3-bit code;
- a control register with a power bit (bit 0) and a source-select bit (bit 7).

When the source-select bit is set, the resolution code and the standby flag given to the display logic come from the registers. When it is clear, they come from strap inputs.

The serial pins are asynchronous to the system clock `clk`. They pass through synchronizers, and an edge detector finds the serial clock edges. Data is sampled on serial clock rising edges and driven on falling edges. A frame-control state machine has these states:

- IDLE: chip select high.
- ADDR: receiving the 7 command bits. Leaves for TURN on a set direction bit, or for PAD on a clear one.
- PAD: consumes the write pad clock, then goes to WDATA.
- WDATA: receives 8 data bits, commits the write, then goes to DONE.
- TURN: consumes the turnaround clock and loads the read value, then goes to LAUNCH.
- LAUNCH: on the next falling edge, drives the first bit, enables the output and goes to RDATA.
- RDATA: shifts out the remaining bits and releases the line on the falling edge of the 16th clock, then goes to DONE.
- DONE: waits for chip select to go high.

From any state other than IDLE, chip select going high returns the machine to IDLE.

Top module: `spi3w_reg_slave`

## Requirements
- R1: After the active-low reset is released, the line enable is 0, the scratch register reads 0x00, the resolution register reads 0x07, the control register reads 0x00, and the outputs follow the straps: resolution code equals strap code, and standby equals the inverse of strap active.
- R2: In a write frame, clocks 1-6 carry address bits [5:0] MSB first, clock 7 carries 0 and clock 8 is a pad. Clocks 9-16 carry the data byte MSB first. The write commits after the 16th rising edge, so a scratch (address 0x00) write of 0x55 reads back as 0x55.
- R3: In a read frame, clocks 1-6 carry the address and clock 7 carries 1. After clock 8, the slave drives the register value MSB first, one bit per falling edge, for the master to sample on rising edges 9-16.
- R4: The slave enables the line only from the falling edge that follows the 8th clock until the falling edge of the 16th clock. It never drives during the command or turnaround clocks.
- R5: Address 0x01 reads {chip code, revision}, which is 0x62 by default. Writes to it have no effect.
- R6: Address 0x02 stores data bits [2:0] as the resolution code. Bits [7:3] read as 0.
- R7: Address 0x03 stores bit 0 (power: 1 = active) and bit 7 (source select: 1 = registers). Its other bits read as 0. The source-select output changes only after a write to 0x03.
- R8: With source select at 1, the resolution output equals the resolution register and standby equals the inverse of the power bit. With source select at 0, both outputs follow the straps.
- R9: Writes to addresses 0x04-0x3F change nothing, and reads from them return 0x00.
- R10: Chip select going high ends any frame and drops the line enable on the next cycle. An aborted write commits nothing, including when chip select rises in the same cycle as the 16th rising edge.
- R11: Asserting reset after configuration returns every register to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low frame select |
| sdio_in | input | 1 | Level seen on the shared data line |
| sdio_out | output | 1 | Value the slave drives onto the data line |
| sdio_oe | output | 1 | Enable for the slave's line driver |
| strap_res | input | 3 | Strap resolution code |
| strap_active | input | 1 | Strap power state (1 = active) |
| res_code | output | 3 | Resolution code to the display logic |
| standby | output | 1 | Standby request to the display logic |
| sw_ctrl | output | 1 | Source select: 1 = registers, 0 = straps |

## Verification
Two functions can land on one system cycle: the frame abort, when the synchronized chip select goes high, and the write commit, on the 16th rising edge of a write frame. The bench raises chip select and the 16th serial clock edge in the same instant, so both reach the edge detector together. It then reads the scratch register through a normal read frame: an unchanged value shows that the abort won. A second collision is between the master's and the slave's drivers on the shared line. The bench checks this on every cycle and also checks the enable at the turnaround clock and after the last data bit.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int RES_W  = 3;

    // Register offsets: the master's software depends on these positions.
    localparam logic [ADDR_W-1:0] ADDR_SCRATCH = 6'h00;
    localparam logic [ADDR_W-1:0] ADDR_IDENT   = 6'h01;
    localparam logic [ADDR_W-1:0] ADDR_RES     = 6'h02;
    localparam logic [ADDR_W-1:0] ADDR_CTRL    = 6'h03;

    // Bit positions in the control register.
    localparam int CTRL_PWR_BIT = 0;
    localparam int CTRL_SRC_BIT = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PAD,
        ST_WDATA,
        ST_TURN,
        ST_LAUNCH,
        ST_RDATA,
        ST_DONE
    } frame_state_t;

endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic sdio_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_idle,
    output logic sdio_s
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] dat_p;
    logic              sck_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p    <= '0;
            cs_p     <= '1;
            dat_p    <= '1;
            sck_last <= 1'b0;
        end else begin
            sck_p[0] <= sck_i;
            cs_p[0]  <= cs_n_i;
            dat_p[0] <= sdio_i;
            for (int i = 1; i < STAGES; i++) begin
                sck_p[i] <= sck_p[i-1];
                cs_p[i]  <= cs_p[i-1];
                dat_p[i] <= dat_p[i-1];
            end
            sck_last <= sck_p[LAST];
        end
    end

    assign sck_rise = sck_p[LAST] & ~sck_last;
    assign sck_fall = ~sck_p[LAST] & sck_last;
    assign cs_idle  = cs_p[LAST];
    assign sdio_s   = dat_p[LAST];

endmodule

// File: rtl/spi3w_frame.sv
module spi3w_frame
    import spi3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_idle,
    input  logic              sdio_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_pulse,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_en
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    frame_state_t      state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        if (cs_idle) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_ADDR;
                ST_ADDR:   if (sck_rise && cnt == CMD_LAST)
                               state_nx = sdio_s ? ST_TURN : ST_PAD;
                ST_PAD:    if (sck_rise) state_nx = ST_WDATA;
                ST_WDATA:  if (sck_rise && cnt == DATA_LAST) state_nx = ST_DONE;
                ST_TURN:   if (sck_rise) state_nx = ST_LAUNCH;
                ST_LAUNCH: if (sck_fall) state_nx = ST_RDATA;
                ST_RDATA:  if (sck_fall && cnt == DATA_LAST) state_nx = ST_DONE;
                ST_DONE:   state_nx = ST_DONE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            shreg    <= '0;
            addr_q   <= '0;
            wr_pulse <= 1'b0;
            wr_data  <= '0;
            sdo      <= 1'b0;
            sdo_en   <= 1'b0;
        end else begin
            wr_pulse <= 1'b0;
            if (cs_idle) begin
                cnt    <= '0;
                sdo_en <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        cnt    <= '0;
                        sdo_en <= 1'b0;
                    end
                    ST_ADDR: if (sck_rise) begin
                        shreg <= {shreg[DATA_W-2:0], sdio_s};
                        if (cnt == CMD_LAST) begin
                            addr_q <= shreg[ADDR_W-1:0];
                            cnt    <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAD: cnt <= '0;
                    ST_WDATA: if (sck_rise) begin
                        shreg <= {shreg[DATA_W-2:0], sdio_s};
                        cnt   <= cnt + 1'b1;
                        if (cnt == DATA_LAST) begin
                            wr_pulse <= 1'b1;
                            wr_data  <= {shreg[DATA_W-2:0], sdio_s};
                        end
                    end
                    ST_TURN: if (sck_rise) shreg <= rd_data;
                    ST_LAUNCH: if (sck_fall) begin
                        sdo    <= shreg[DATA_W-1];
                        sdo_en <= 1'b1;
                        shreg  <= {shreg[DATA_W-2:0], 1'b0};
                        cnt    <= '0;
                    end
                    ST_RDATA: if (sck_fall) begin
                        if (cnt == DATA_LAST) begin
                            sdo_en <= 1'b0;
                        end else begin
                            sdo   <= shreg[DATA_W-1];
                            shreg <= {shreg[DATA_W-2:0], 1'b0};
                            cnt   <= cnt + 1'b1;
                        end
                    end
                    ST_DONE: sdo_en <= 1'b0;
                    default: sdo_en <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi3w_regs.sv
module spi3w_regs
    import spi3w_pkg::*;
#(
    parameter logic [3:0]       CHIP_CODE = 4'h6,
    parameter logic [3:0]       REVISION  = 4'h2,
    parameter logic [RES_W-1:0] RES_RST   = 3'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [RES_W-1:0]  strap_res,
    input  logic              strap_active,
    output logic [RES_W-1:0]  res_code,
    output logic              standby,
    output logic              sw_ctrl
);

    logic [DATA_W-1:0] scratch_q;
    logic [RES_W-1:0]  res_q;
    logic              pwr_q;
    logic              src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scratch_q <= '0;
            res_q     <= RES_RST;
            pwr_q     <= 1'b0;
            src_q     <= 1'b0;
        end else if (wr_pulse) begin
            unique case (addr)
                ADDR_SCRATCH: scratch_q <= wr_data;
                ADDR_RES:     res_q     <= wr_data[RES_W-1:0];
                ADDR_CTRL: begin
                    pwr_q <= wr_data[CTRL_PWR_BIT];
                    src_q <= wr_data[CTRL_SRC_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            ADDR_SCRATCH: rd_data = scratch_q;
            ADDR_IDENT:   rd_data = {CHIP_CODE, REVISION};
            ADDR_RES:     rd_data[RES_W-1:0] = res_q;
            ADDR_CTRL: begin
                rd_data[CTRL_PWR_BIT] = pwr_q;
                rd_data[CTRL_SRC_BIT] = src_q;
            end
            default: rd_data = '0;
        endcase
    end

    assign sw_ctrl  = src_q;
    assign res_code = src_q ? res_q : strap_res;
    assign standby  = src_q ? ~pwr_q : ~strap_active;

endmodule

// File: rtl/spi3w_reg_slave.sv
module spi3w_reg_slave
    import spi3w_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [3:0]       CHIP_CODE   = 4'h6,
    parameter logic [3:0]       REVISION    = 4'h2,
    parameter logic [RES_W-1:0] RES_RST     = 3'd7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sck,
    input  logic             spi_cs_n,
    input  logic             sdio_in,
    output logic             sdio_out,
    output logic             sdio_oe,
    input  logic [RES_W-1:0] strap_res,
    input  logic             strap_active,
    output logic [RES_W-1:0] res_code,
    output logic             standby,
    output logic             sw_ctrl
);

    logic              sck_rise, sck_fall, cs_idle, sdio_s;
    logic [ADDR_W-1:0] reg_addr;
    logic              wr_pulse;
    logic [DATA_W-1:0] wr_data, rd_data;

    spi3w_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (spi_sck),
        .cs_n_i   (spi_cs_n),
        .sdio_i   (sdio_in),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_idle  (cs_idle),
        .sdio_s   (sdio_s)
    );

    spi3w_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_idle  (cs_idle),
        .sdio_s   (sdio_s),
        .rd_data  (rd_data),
        .addr_q   (reg_addr),
        .wr_pulse (wr_pulse),
        .wr_data  (wr_data),
        .sdo      (sdio_out),
        .sdo_en   (sdio_oe)
    );

    spi3w_regs #(
        .CHIP_CODE (CHIP_CODE),
        .REVISION  (REVISION),
        .RES_RST   (RES_RST)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_pulse     (wr_pulse),
        .addr         (reg_addr),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .strap_res    (strap_res),
        .strap_active (strap_active),
        .res_code     (res_code),
        .standby      (standby),
        .sw_ctrl      (sw_ctrl)
    );

endmodule

// File: rtl/spi3w_reg_slave_chk.sv
module spi3w_reg_slave_chk
    import spi3w_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_idle,
    input logic              sck_fall,
    input logic              sdio_oe,
    input logic              wr_pulse,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [RES_W-1:0]  res_code,
    input logic              sw_ctrl
);

    // R10
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> !sdio_oe);

    // R4
    drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe) |-> $past(sck_fall));

    // R2
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R7
    src_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sw_ctrl) |-> ($past(wr_pulse) && $past(reg_addr) == ADDR_CTRL));

    // R6
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ctrl && $past(sw_ctrl) && !$past(wr_pulse)) |-> $stable(res_code));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && reg_addr > ADDR_CTRL) |=> $stable(sw_ctrl));

endmodule

bind spi3w_reg_slave spi3w_reg_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_idle  (cs_idle),
    .sck_fall (sck_fall),
    .sdio_oe  (sdio_oe),
    .wr_pulse (wr_pulse),
    .reg_addr (reg_addr),
    .res_code (res_code),
    .sw_ctrl  (sw_ctrl)
);

// File: tb/spi3w_reg_slave_tb_top.sv
`timescale 1ns/1ps
module spi3w_reg_slave_tb_top;

    localparam int HALF = 10;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       m_en = 1'b0;
    logic       m_bit = 1'b1;
    logic [2:0] strap_res = 3'd5;
    logic       strap_active = 1'b1;
    logic       sdio_out, sdio_oe, standby, sw_ctrl;
    logic [2:0] res_code;
    logic       line;

    int checks = 0;
    int errors = 0;
    exp_t       exp_q[$];
    logic [7:0] got_q[$];

    always #2 clk = ~clk;

    // Shared line with a pull-up when nobody drives.
    assign line = sdio_oe ? sdio_out : (m_en ? m_bit : 1'b1);

    spi3w_reg_slave dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sck      (sck),
        .spi_cs_n     (cs_n),
        .sdio_in      (line),
        .sdio_out     (sdio_out),
        .sdio_oe      (sdio_oe),
        .strap_res    (strap_res),
        .strap_active (strap_active),
        .res_code     (res_code),
        .standby      (standby),
        .sw_ctrl      (sw_ctrl)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_write(input logic [5:0] a, input logic [7:0] d,
                             input int nclk, input bit cs_with_last);
        logic [15:0] bits;
        bits = {a, 1'b0, 1'b0, d};
        cs_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nclk; i++) begin
            m_en  = 1'b1;
            m_bit = bits[15-i];
            tick(HALF);
            if (cs_with_last && i == nclk - 1) cs_n = 1'b1;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        m_en = 1'b0;
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic spi_read(input logic [5:0] a, input int nbits);
        logic [6:0] cmd;
        logic [7:0] got;
        cmd = {a, 1'b1};
        got = '0;
        cs_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < 7; i++) begin
            m_en  = 1'b1;
            m_bit = cmd[6-i];
            tick(HALF);
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        m_en = 1'b0;
        tick(HALF);
        check(sdio_oe == 1'b0, "R4 turnaround undriven", int'(sdio_oe), 0);
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            tick(HALF);
            check(sdio_oe == 1'b1, "R4 data phase driven", int'(sdio_oe), 1);
            got = {got[6:0], line};
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        tick(HALF);
        if (nbits == 8) begin
            check(sdio_oe == 1'b0, "R4 released after last bit", int'(sdio_oe), 0);
            got_q.push_back(got);
        end
        cs_n = 1'b1;
        tick(2 * HALF);
        check(sdio_oe == 1'b0, "R10 released with select high", int'(sdio_oe), 0);
    endtask

    task automatic expect_read(input logic [5:0] a, input logic [7:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
        spi_read(a, 8);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() != 0 && exp_q.size() != 0) begin
                exp_t       e;
                logic [7:0] g;
                e = exp_q.pop_front();
                g = got_q.pop_front();
                check(g == e.val, e.tag, int'(g), int'(e.val));
            end
        end
    end

    // Contention on the shared line
    always @(negedge clk) begin
        if (rst_n && sdio_oe && m_en) begin
            check(1'b0, "R4 line contention", 1, 0);
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1 reset state
        check(sdio_oe == 1'b0, "R1 line enable", int'(sdio_oe), 0);
        check(sw_ctrl == 1'b0, "R1 source select", int'(sw_ctrl), 0);
        check(res_code == 3'd5, "R1 strap resolution", int'(res_code), 5);
        check(standby == 1'b0, "R1 strap standby", int'(standby), 0);
        expect_read(6'h00, 8'h00, "R1 scratch reset");
        expect_read(6'h02, 8'h07, "R1 resolution reset");
        expect_read(6'h03, 8'h00, "R1 control reset");

        // R2 / R3 scratch round trips
        spi_write(6'h00, 8'h55, 16, 1'b0);
        expect_read(6'h00, 8'h55, "R2 scratch 0x55");
        spi_write(6'h00, 8'hA3, 16, 1'b0);
        expect_read(6'h00, 8'hA3, "R3 scratch 0xA3");

        // R5 identity
        expect_read(6'h01, 8'h62, "R5 identity");
        spi_write(6'h01, 8'hFF, 16, 1'b0);
        expect_read(6'h01, 8'h62, "R5 identity after write");

        // R6 resolution register
        spi_write(6'h02, 8'hFE, 16, 1'b0);
        expect_read(6'h02, 8'h06, "R6 resolution masked");
        check(res_code == 3'd5, "R8 straps while select clear", int'(res_code), 5);

        // R7 / R8 control register
        spi_write(6'h03, 8'hFF, 16, 1'b0);
        expect_read(6'h03, 8'h81, "R7 control masked");
        check(sw_ctrl == 1'b1, "R7 source select set", int'(sw_ctrl), 1);
        check(res_code == 3'd6, "R8 register resolution", int'(res_code), 6);
        check(standby == 1'b0, "R8 register active", int'(standby), 0);
        spi_write(6'h03, 8'h80, 16, 1'b0);
        check(standby == 1'b1, "R8 register standby", int'(standby), 1);
        strap_res = 3'd2;
        tick(4);
        check(res_code == 3'd6, "R8 strap ignored", int'(res_code), 6);

        // R9 unmapped addresses
        spi_write(6'h2A, 8'h77, 16, 1'b0);
        expect_read(6'h2A, 8'h00, "R9 unmapped read");
        expect_read(6'h04, 8'h00, "R9 unmapped read 0x04");
        expect_read(6'h00, 8'hA3, "R9 scratch untouched");
        expect_read(6'h03, 8'h80, "R9 control untouched");

        // R10 aborts
        spi_write(6'h00, 8'h12, 12, 1'b0);
        expect_read(6'h00, 8'hA3, "R10 partial write dropped");
        spi_write(6'h00, 8'h34, 16, 1'b1);
        expect_read(6'h00, 8'hA3, "R10 coincident abort");
        spi_read(6'h00, 3);
        expect_read(6'h01, 8'h62, "R10 read after aborted read");

        // R11 reset after configuration
        rst_n = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        check(sw_ctrl == 1'b0, "R11 source select cleared", int'(sw_ctrl), 0);
        check(res_code == 3'd2, "R11 straps again", int'(res_code), 2);
        expect_read(6'h00, 8'h00, "R11 scratch cleared");
        expect_read(6'h02, 8'h07, "R11 resolution reset");

        tick(10);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule